// File: doc/BRIEF.md
# Dual retriggerable one-shot pulse generator

This block holds two independent one-shot channels that run from a single system clock. Each channel watches three asynchronous control lines: an active-low fall trigger, an active-high rise trigger and an active-low hold line. When a qualifying edge arrives, the channel raises its output for a programmed number of clock cycles. A new qualifying edge during a pulse reloads the full width. While the hold line is low, the output is forced low and every trigger is blocked. A build-time parameter selects whether releasing the hold line can start a pulse by itself.

Each control line passes through a two-flop synchroniser and then an edge-detect register. A pulse therefore starts on the third clock edge after the line changes. The width of each channel comes from its own port. The port is read on the trigger cycle, so a width of zero gives no pulse. After power-up reset, the edge logic stays idle until the synchronisers hold real samples. Lines that are already at a triggering level when reset ends cannot fire a pulse. The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level.

Top module: `oneshot_pair`

## Requirements
- R1: The two channels are fully independent. Stimulus on one channel never changes the outputs of the other.
- R2: A high-to-low change on a channel's fall trigger starts a pulse when that channel's rise trigger is high. It does nothing when the rise trigger is low.
- R3: A low-to-high change on a channel's rise trigger starts a pulse when that channel's fall trigger is low. It does nothing when the fall trigger is high. A rising fall trigger and a falling rise trigger never start a pulse.
- R4: Let a trigger line change between clock edges. The output goes high on the third following clock edge and stays high for exactly WIDTH cycles. WIDTH is the channel's 16-bit slice of `width_i`: bits [15:0] for channel 0 and bits [31:16] for channel 1.
- R5: A qualifying trigger during a pulse reloads the full WIDTH. The pulse then ends WIDTH cycles after the latest trigger.
- R6: When a channel's hold line goes low, its output goes low by the second following clock edge. The output stays low, and every trigger is ignored, while the hold line stays low.
- R7: With RST_TRIG=1, a low-to-high change on the hold line starts a pulse when the fall trigger is low and the rise trigger is high. It does not start a pulse when the fall trigger is high. With RST_TRIG=0, releasing the hold line never starts a pulse.
- R8: A trigger with WIDTH equal to 0 produces no pulse.
- R9: Each complementary output is always the exact inverse of its true output.
- R10: During and after power-up reset, the outputs are low. Trigger levels that are present while reset is released do not start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset, synchronous |
| fall_trig_i | input | NCH | Active-low trigger, fires on a falling change, one bit per channel |
| rise_trig_i | input | NCH | Active-high trigger, fires on a rising change, one bit per channel |
| hold_n_i | input | NCH | Active-low hold, clears and blocks the pulse, one bit per channel |
| width_i | input | NCH*CW | Pulse width in clock cycles, CW bits per channel |
| q_o | output | NCH | True pulse output per channel |
| qn_o | output | NCH | Complementary pulse output per channel |

## Verification
The counter assertions assume one thing about the inputs: `width_i` is stable on every cycle in which a trigger can fire. The width is read only on that cycle and is not synchronised. The bench changes a width only while both channels are idle and their triggers are at rest. The trigger and hold lines may be fully asynchronous. Even so, the bench changes them only just after a falling clock edge and keeps each level for at least two cycles, so that every edge passes the synchroniser. The bench then samples the outputs on the exact cycle that R4 and R6 predict. A second instance built with RST_TRIG=0 receives the same stimulus, so both variants of R7 are checked at once.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Synchronised view of one channel's control lines; a is the MSB.
  typedef struct packed {
    logic a;   // fall trigger, active low
    logic b;   // rise trigger, active high
    logic r;   // hold, active low
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/os_arm.sv
module os_arm #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  localparam int WARM = STAGES + 1;
  localparam int AW   = $clog2(WARM + 1);

  logic [AW-1:0] wc;

  always_ff @(posedge clk) begin
    if (!rst_n)                  wc <= '0;
    else if (wc != AW'(WARM))    wc <= wc + AW'(1);
  end

  assign armed = (wc == AW'(WARM));
endmodule

// File: rtl/os_trig.sv
module os_trig
  import oneshot_pkg::*;
#(
  parameter bit RST_TRIG = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  armed,
  input  pins_t cur,
  output logic  fire,
  output logic  clr_ok
);
  pins_t prev;
  logic  fall_a, rise_b, rel_r;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  assign fall_a = prev.a & ~cur.a & cur.b;
  assign rise_b = ~prev.b & cur.b & ~cur.a;

  if (RST_TRIG) begin : g_rel
    assign rel_r = ~prev.r & cur.r & ~cur.a & cur.b;
  end else begin : g_norel
    assign rel_r = 1'b0;
  end

  assign clr_ok = cur.r;
  assign fire   = armed & cur.r & (fall_a | rise_b | rel_r);
endmodule

// File: rtl/os_count.sv
module os_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          clr_ok,
  input  logic [CW-1:0] width,
  output logic          q
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!clr_ok)    cnt <= '0;
    else if (fire)       cnt <= width;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign q = (cnt != '0) & clr_ok;

  // R6
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> (cnt == '0));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_ok) |=> (cnt == $past(width)));

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !fire && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(fire));

  // R8
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_ok && width == '0) |=> (cnt == '0));
endmodule

// File: rtl/oneshot_pair.sv
module oneshot_pair
  import oneshot_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CW       = 16,
  parameter int STAGES   = 2,
  parameter bit RST_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fall_trig_i,
  input  logic [NCH-1:0]    rise_trig_i,
  input  logic [NCH-1:0]    hold_n_i,
  input  logic [NCH*CW-1:0] width_i,
  output logic [NCH-1:0]    q_o,
  output logic [NCH-1:0]    qn_o
);
  logic armed;

  os_arm #(.STAGES(STAGES)) u_arm (
    .clk(clk), .rst_n(rst_n), .armed(armed)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PINS_W-1:0] syn;
    pins_t             cur;
    logic              fire, clr_ok, q;

    os_sync #(.W(PINS_W), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({fall_trig_i[c], rise_trig_i[c], hold_n_i[c]}),
      .q(syn)
    );

    assign cur = pins_t'(syn);

    os_trig #(.RST_TRIG(RST_TRIG)) u_trig (
      .clk(clk), .rst_n(rst_n), .armed(armed), .cur(cur),
      .fire(fire), .clr_ok(clr_ok)
    );

    os_count #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .fire(fire), .clr_ok(clr_ok),
      .width(width_i[c*CW +: CW]), .q(q)
    );

    assign q_o[c]  = q;
    assign qn_o[c] = ~q;
  end

  // R10
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (q_o == '0));
endmodule

// File: tb/sim_oneshot_pair.sv
module sim_oneshot_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fa = 2'b11, rb = 2'b00, hn = 2'b11;
  logic [31:0] wid = '0;
  logic [1:0]  q0, qn0, q1, qn1;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oneshot_pair #(.RST_TRIG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .fall_trig_i(fa), .rise_trig_i(rb),
    .hold_n_i(hn), .width_i(wid), .q_o(q0), .qn_o(qn0)
  );

  oneshot_pair #(.RST_TRIG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .fall_trig_i(fa), .rise_trig_i(rb),
    .hold_n_i(hn), .width_i(wid), .q_o(q1), .qn_o(qn1)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // dut 0 = RST_TRIG=1, dut 1 = RST_TRIG=0; also checks R9 on the same channel
  task automatic chq(input string req, input int dut, input int c, input int exp);
    int q, qn;
    q  = (dut == 0) ? int'(q0[c])  : int'(q1[c]);
    qn = (dut == 0) ? int'(qn0[c]) : int'(qn1[c]);
    chk(req, q, exp);
    chk("R9 complement", qn, (exp == 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    fa = 2'b00; rb = 2'b11; hn = 2'b11;
    wid = {16'd4, 16'd4};
    step(3);
    chq("R10 reset state", 0, 0, 0);
    chq("R10 reset state", 0, 1, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      chq("R10 no start from levels at reset", 0, 0, 0);
      chq("R10 no start from levels at reset", 0, 1, 0);
    end
    fa = 2'b11; rb = 2'b00;
    step(5);
    chq("R3 rising fall trig / falling rise trig idle", 0, 0, 0);
  endtask

  task automatic t_fall_a;
    wid[15:0] = 16'd5;
    rb[0] = 1'b1;
    step(5);
    chq("R3 rise trig with fall trig high ignored", 0, 0, 0);
    fa[0] = 1'b0;
    step(2);
    chq("R4 not yet high at second edge", 0, 0, 0);
    step(1);
    chq("R2 fall trig starts pulse", 0, 0, 1);
    chq("R1 other channel quiet", 0, 1, 0);
    step(4);
    chq("R4 last high cycle", 0, 0, 1);
    step(1);
    chq("R4 pulse ends after WIDTH", 0, 0, 0);
    fa[0] = 1'b1; rb[0] = 1'b0;
    step(5);
    chq("R3 release edges do not trigger", 0, 0, 0);
  endtask

  task automatic t_rise_b;
    wid[15:0] = 16'd3;
    fa[0] = 1'b0;
    step(5);
    chq("R2 fall trig with rise trig low ignored", 0, 0, 0);
    rb[0] = 1'b1;
    step(3);
    chq("R3 rise trig starts pulse", 0, 0, 1);
    chq("R1 other channel quiet", 0, 1, 0);
    step(2);
    chq("R4 last high cycle", 0, 0, 1);
    step(1);
    chq("R4 pulse ends after WIDTH", 0, 0, 0);
    rb[0] = 1'b0; fa[0] = 1'b1;
    step(5);
  endtask

  task automatic t_retrig;
    wid[31:16] = 16'd6;
    fa[1] = 1'b0;
    step(4);
    rb[1] = 1'b1;
    step(2);
    rb[1] = 1'b0;
    step(1);
    chq("R3 channel 1 start", 0, 1, 1);
    chq("R1 channel 0 quiet", 0, 0, 0);
    step(1);
    rb[1] = 1'b1;
    step(6);
    chq("R5 pulse extended past first end", 0, 1, 1);
    step(2);
    chq("R5 last high cycle after retrigger", 0, 1, 1);
    step(1);
    chq("R5 ends WIDTH after latest trigger", 0, 1, 0);
    fa[1] = 1'b1; rb[1] = 1'b0;
    step(5);
  endtask

  task automatic t_hold;
    wid[15:0] = 16'd20;
    rb[0] = 1'b1;
    step(4);
    fa[0] = 1'b0;
    step(3);
    chq("R2 start before hold", 0, 0, 1);
    step(2);
    hn[0] = 1'b0;
    step(1);
    chq("R6 still high one edge after hold", 0, 0, 1);
    step(1);
    chq("R6 hold forces low", 0, 0, 0);
    chq("R1 channel 1 untouched", 0, 1, 0);
    fa[0] = 1'b1;
    step(3);
    fa[0] = 1'b0;
    step(4);
    chq("R6 trigger ignored while held", 0, 0, 0);
    hn[0] = 1'b1;
    step(2);
    chq("R7 not yet high", 0, 0, 0);
    step(1);
    chq("R7 release starts pulse with RST_TRIG=1", 0, 0, 1);
    chq("R7 release ignored with RST_TRIG=0", 1, 0, 0);
    step(20);
    chq("R7 release pulse ends after WIDTH", 0, 0, 0);
    fa[0] = 1'b1;
    step(4);
    hn[0] = 1'b0;
    step(4);
    hn[0] = 1'b1;
    step(5);
    chq("R7 release with fall trig high ignored", 0, 0, 0);
    rb[0] = 1'b0;
    step(4);
  endtask

  task automatic t_zero;
    wid[31:16] = 16'd0;
    rb[1] = 1'b1;
    step(4);
    fa[1] = 1'b0;
    step(3);
    chq("R8 zero width no pulse", 0, 1, 0);
    step(1);
    chq("R8 zero width no pulse", 0, 1, 0);
    fa[1] = 1'b1; rb[1] = 1'b0;
    step(4);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_fall_a();
    t_rise_b();
    t_retrig();
    t_hold();
    t_zero();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule